// File: doc/BRIEF.md
# Media Engine Command Stream Decoder

This block sits at the front of a media engine and turns a flat stream of 32-bit command dwords into decoded commands. Dwords arrive on a valid/ready interface. The first dword of each command is a header. The decoder checks the header's fixed identity fields, reads the command sub-number, and takes the command length from a length field that is biased by two. It then collects the payload dwords and presents the whole command, with its kind and payload on a wide bus, through a single held strobe.

A header is rejected if its identity fields are wrong, if its sub-number is unknown, or if its length does not match the length defined for that sub-number. A rejected header sets a sticky error flag. The decoder still uses the header's length field to step over the command's dwords, so the next header is found in the right place.

Two pieces of pipeline configuration are kept in registers for later use: the stream-out enable and the soft-reset counter. Both come from the pipe-mode command.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header is accepted only if bits 31:29 equal 3, bits 28:27 equal 2 and bits 26:23 equal 0xB. Any other value sets the error flag and produces no strobe.
- R2: Bits 11:0 of every header, legal or not, hold the command's total dword count minus two. After the header, exactly that field plus one further dwords are consumed before the next header is looked for.
- R3: Bits 22:16 give the sub-number. The known sub-numbers and their total lengths are: 0 → 3, 1 → 5, 2 → 6, 3 → 2, 4 → 49, 5 → 11, 32 → 5, 33 → 2. Any other sub-number is treated as illegal.
- R4: A known sub-number whose length field differs from its defined length minus two is illegal. Its dwords are skipped and no strobe is raised.
- R5: After the last payload dword of a legal command is taken, outValid rises on the following edge. At that point outKind holds the sub-number, and payload dword i (the dword i+1 positions after the header) sits on outPayload bits 32i+31:32i. All unused payload words read zero. The outputs hold steady until outReady is seen high.
- R6: cmdReady is low for as long as outValid is high, and high in every other cycle.
- R7: After reset, cmdReady is 1 and outValid, errSticky, cfgStreamOut and cfgSoftReset are 0. Once errSticky is set, it stays set until reset.
- R8: A legal pipe-mode command (sub-number 0) loads cfgStreamOut from bit 4 of its payload dword 0 and cfgSoftReset from its payload dword 1. Both registers change on the edge where outValid rises, and at no other time; a rejected pipe-mode command leaves them unchanged.
- R9: outLast equals bit 0 of payload dword 0 while a start command (sub-number 33) is being presented, and is 0 at all other times.
- R10: The dword that follows a skipped or completed command is decoded as a header, with no lost or extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command dword valid |
| cmdData | input | 32 | Command dword |
| cmdReady | output | 1 | Decoder can take a dword |
| outValid | output | 1 | Decoded command is being presented |
| outReady | input | 1 | Downstream accepts the presented command |
| outKind | output | 7 | Sub-number of the presented command |
| outPayload | output | PAY_DW*32 | Payload dwords, dword 0 in the low bits |
| outLast | output | 1 | Start command flags the last stream object |
| errSticky | output | 1 | An illegal header has been seen since reset |
| cfgStreamOut | output | 1 | Stored stream-out enable |
| cfgSoftReset | output | 32 | Stored soft-reset counter |

## Verification
The bench walks through every combination of the three fixed identity fields and every sub-number. It also tries each known command with its length field one above and one below the correct value. After every rejected header it sends a legal start command, so a decoder that skipped one dword too few or too many would misread that command and never raise its strobe. Legal commands, including the 49-dword one, have every payload word compared, and the unused words are checked for zero. This catches a write index that is off by one or payload left over from an earlier command. Further checks hold the strobe with outReady low, reject a pipe-mode command with a bad length and confirm the configuration did not move, and confirm the error flag stays set after later legal traffic.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int SUB_W  = 7;

  // fixed identity codes every header must carry
  localparam logic [2:0] HDR_CTYPE = 3'd3;
  localparam logic [1:0] HDR_PIPE  = 2'd2;
  localparam logic [3:0] HDR_OPC   = 4'hB;

  localparam logic [SUB_W-1:0] SUB_PIPE_MODE = 7'd0;
  localparam logic [SUB_W-1:0] SUB_START     = 7'd33;

  // total command length in dwords for a sub-number; 0 marks an unknown one
  function automatic logic [5:0] expTotal(input logic [SUB_W-1:0] sub);
    case (sub)
      7'd0:    expTotal = 6'd3;
      7'd1:    expTotal = 6'd5;
      7'd2:    expTotal = 6'd6;
      7'd3:    expTotal = 6'd2;
      7'd4:    expTotal = 6'd49;
      7'd5:    expTotal = 6'd11;
      7'd32:   expTotal = 6'd5;
      7'd33:   expTotal = 6'd2;
      default: expTotal = 6'd0;
    endcase
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic hdrTake;   // legal header accepted
    logic payWrite;  // payload dword accepted
    logic cfgLoad;   // final dword of a pipe-mode command
    logic errSet;    // illegal header accepted
  } csd_ctl_t;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_PAY,
    ST_SKIP,
    ST_HOLD
  } csd_state_e;

endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [15:0]      hdrHi,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output csd_ctl_t         ctl
);

  localparam int REM_W = LEN_W + 1;

  csd_state_e       state;
  logic [REM_W-1:0] remaining;
  logic             isPipeMode;

  logic             fire;
  logic [2:0]       fCtype;
  logic [1:0]       fPipe;
  logic [3:0]       fOpc;
  logic [SUB_W-1:0] fSub;
  logic [5:0]       total;
  logic             idOk;
  logic             known;
  logic             lenOk;
  logic             legal;
  logic             lastBeat;

  always_comb begin
    fCtype = hdrHi[15:13];
    fPipe  = hdrHi[12:11];
    fOpc   = hdrHi[10:7];
    fSub   = hdrHi[6:0];
    total  = expTotal(fSub);
    idOk   = (fCtype == HDR_CTYPE) && (fPipe == HDR_PIPE) && (fOpc == HDR_OPC);
    known  = (total != 6'd0);
    lenOk  = (hdrLen == LEN_W'(total - 6'd2));
    legal  = idOk && known && lenOk;
  end

  assign inReady  = (state != ST_HOLD);
  assign outValid = (state == ST_HOLD);
  assign fire     = inValid && inReady;
  assign lastBeat = (remaining == REM_W'(1));

  always_comb begin
    ctl          = '0;
    ctl.hdrTake  = (state == ST_HDR) && fire && legal;
    ctl.errSet   = (state == ST_HDR) && fire && !legal;
    ctl.payWrite = (state == ST_PAY) && fire;
    ctl.cfgLoad  = (state == ST_PAY) && fire && lastBeat && isPipeMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HDR;
      remaining  <= '0;
      isPipeMode <= 1'b0;
    end else begin
      case (state)
        ST_HDR: begin
          if (fire) begin
            remaining  <= {1'b0, hdrLen} + REM_W'(1);
            isPipeMode <= (fSub == SUB_PIPE_MODE);
            state      <= legal ? ST_PAY : ST_SKIP;
          end
        end
        ST_PAY: begin
          if (fire) begin
            remaining <= remaining - REM_W'(1);
            if (lastBeat) state <= ST_HOLD;
          end
        end
        ST_SKIP: begin
          if (fire) begin
            remaining <= remaining - REM_W'(1);
            if (lastBeat) state <= ST_HDR;
          end
        end
        default: begin
          if (outReady) state <= ST_HDR;
        end
      endcase
    end
  end

endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int PAY_DW = 48
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WORD_W-1:0]        inData,
  input  csd_ctl_t                 ctl,
  input  logic                     holding,
  output logic [SUB_W-1:0]         outKind,
  output logic [PAY_DW*WORD_W-1:0] outPayload,
  output logic                     outLast,
  output logic                     errSticky,
  output logic                     cfgStreamOut,
  output logic [WORD_W-1:0]        cfgSoftReset
);

  localparam int IDX_W = $clog2(PAY_DW + 1);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] firstWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      outKind <= '0;
    end else if (ctl.hdrTake) begin
      idx     <= '0;
      outKind <= inData[22:16];
    end else if (ctl.payWrite) begin
      idx <= idx + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < PAY_DW; g++) begin : g_word
    logic [WORD_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 word <= '0;
      else if (ctl.hdrTake)                      word <= '0;
      else if (ctl.payWrite && idx == IDX_W'(g)) word <= inData;
    end
    assign outPayload[WORD_W*g +: WORD_W] = word;
  end

  assign firstWord = outPayload[WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky    <= 1'b0;
      cfgStreamOut <= 1'b0;
      cfgSoftReset <= '0;
    end else begin
      if (ctl.errSet) errSticky <= 1'b1;
      if (ctl.cfgLoad) begin
        cfgStreamOut <= firstWord[4];
        cfgSoftReset <= inData;
      end
    end
  end

  assign outLast = holding && (outKind == SUB_START) && firstWord[0];

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import csd_pkg::*;
#(
  parameter int PAY_DW = 48
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [31:0]              cmdData,
  output logic                     cmdReady,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [6:0]               outKind,
  output logic [PAY_DW*32-1:0]     outPayload,
  output logic                     outLast,
  output logic                     errSticky,
  output logic                     cfgStreamOut,
  output logic [31:0]              cfgSoftReset
);

  csd_ctl_t ctl;

  csd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (cmdValid),
    .hdrHi    (cmdData[31:16]),
    .hdrLen   (cmdData[LEN_W-1:0]),
    .outReady (outReady),
    .inReady  (cmdReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  csd_datapath #(.PAY_DW(PAY_DW)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (cmdData),
    .ctl          (ctl),
    .holding      (outValid),
    .outKind      (outKind),
    .outPayload   (outPayload),
    .outLast      (outLast),
    .errSticky    (errSticky),
    .cfgStreamOut (cfgStreamOut),
    .cfgSoftReset (cfgSoftReset)
  );

endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
  parameter int PAY_DW = 48
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdReady,
  input logic                 outValid,
  input logic                 outReady,
  input logic [6:0]           outKind,
  input logic [PAY_DW*32-1:0] outPayload,
  input logic                 outLast,
  input logic                 errSticky,
  input logic                 cfgStreamOut,
  input logic [31:0]          cfgSoftReset
);

  AST_HOLD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !cmdReady); // R6

  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKind) && $stable(outPayload))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R7

  AST_KIND_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (csd_pkg::expTotal(outKind) != 6'd0)); // R3

  AST_CFG_ON_PIPE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(cfgSoftReset) || !$stable(cfgStreamOut)) |-> ($rose(outValid) && outKind == 7'd0)); // R8

  AST_LAST_ONLY_START: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outValid && outKind == 7'd33)); // R9

endmodule

bind cmd_stream_decoder csd_chk #(.PAY_DW(PAY_DW)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cmdReady     (cmdReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outKind      (outKind),
  .outPayload   (outPayload),
  .outLast      (outLast),
  .errSticky    (errSticky),
  .cfgStreamOut (cfgStreamOut),
  .cfgSoftReset (cfgSoftReset)
);

// File: tb/cmd_stream_decoder_tb.sv
module cmd_stream_decoder_tb_top;

  localparam int PAY_DW = 48;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 cmdValid = 1'b0;
  logic [31:0]          cmdData = '0;
  logic                 cmdReady;
  logic                 outValid;
  logic                 outReady = 1'b0;
  logic [6:0]           outKind;
  logic [PAY_DW*32-1:0] outPayload;
  logic                 outLast;
  logic                 errSticky;
  logic                 cfgStreamOut;
  logic [31:0]          cfgSoftReset;

  int nRun  = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  cmd_stream_decoder #(.PAY_DW(PAY_DW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdReady(cmdReady), .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outPayload(outPayload), .outLast(outLast),
    .errSticky(errSticky), .cfgStreamOut(cfgStreamOut), .cfgSoftReset(cfgSoftReset)
  );

  function automatic int tbTotal(input int sub);
    case (sub)
      0: return 3;  1: return 5;  2: return 6;  3: return 2;
      4: return 49; 5: return 11; 32: return 5; 33: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mkHdr(input int ct, input int pp, input int op,
                                        input int sub, input int len);
    return {3'(ct), 2'(pp), 4'(op), 7'(sub), 4'b0, 12'(len)};
  endfunction

  function automatic logic [31:0] pat(input int seed, input int i);
    return (32'(seed) << 24) ^ (32'(i) * 32'h0001_0101) ^ 32'h00C3_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    cmdValid = 1'b0;
    outReady = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = d;
    @(posedge clk);
    #1 cmdValid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  task automatic sendPat(input logic [31:0] hdr, input int n, input int seed);
    push(hdr);
    for (int i = 0; i < n; i++) push(pat(seed, i));
  endtask

  // check presented strobe against the pattern payload, then accept it
  task automatic expectStrobe(input int sub, input int n, input int seed, input string tag);
    @(negedge clk);
    chk(outValid == 1'b1, {tag, " R5 strobe"}, 64'(outValid), 64'd1);
    chk(outKind == 7'(sub), {tag, " R3 kind"}, 64'(outKind), 64'(sub));
    chk(cmdReady == 1'b0, {tag, " R6 ready low"}, 64'(cmdReady), 64'd0);
    for (int i = 0; i < PAY_DW; i++) begin
      logic [31:0] e;
      e = (i < n) ? pat(seed, i) : 32'd0;
      chk(outPayload[32*i +: 32] == e, {tag, " R5 payload"}, 64'(outPayload[32*i +: 32]), 64'(e));
    end
    chk(outLast == ((sub == 33) ? pat(seed, 0) : 32'd0) % 2, {tag, " R9 last"}, 64'(outLast), 64'd0);
    accept();
    @(negedge clk);
    chk(outValid == 1'b0 && cmdReady == 1'b1, {tag, " R6 released"}, 64'({outValid, cmdReady}), 64'b01);
  endtask

  // legal start with last flag set, checks alignment after a prior command
  task automatic startProbe(input string tag);
    push(mkHdr(3, 2, 11, 33, 0));
    push(32'h0000_0001);
    @(negedge clk);
    chk(outValid == 1'b1 && outKind == 7'd33, {tag, " R10 realign"}, 64'({outValid, outKind}), 64'({1'b1, 7'd33}));
    chk(outLast == 1'b1, {tag, " R9 last set"}, 64'(outLast), 64'd1);
    accept();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R7 reset state
    chk(cmdReady == 1'b1, "R7 reset ready", 64'(cmdReady), 64'd1);
    chk(outValid == 1'b0, "R7 reset outValid", 64'(outValid), 64'd0);
    chk(errSticky == 1'b0, "R7 reset err", 64'(errSticky), 64'd0);
    chk(cfgStreamOut == 1'b0 && cfgSoftReset == 32'd0, "R7 reset cfg", 64'(cfgSoftReset), 64'd0);

    // R3 R5: every known command with its correct length
    for (int s = 0; s < 128; s++) begin
      int t;
      t = tbTotal(s);
      if (t != 0) begin
        sendPat(mkHdr(3, 2, 11, s, t - 2), t - 1, s + 7);
        expectStrobe(s, t - 1, s + 7, "R3 legal");
      end
    end
    chk(errSticky == 1'b0, "R3 no error on legal", 64'(errSticky), 64'd0);

    // R6 hold: outputs stay while outReady is low
    sendPat(mkHdr(3, 2, 11, 32, 3), 4, 99);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(outValid == 1'b1 && cmdReady == 1'b0, "R6 hold", 64'({outValid, cmdReady}), 64'b10);
      chk(outPayload[127:96] == pat(99, 3), "R5 hold payload", 64'(outPayload[127:96]), 64'(pat(99, 3)));
    end
    accept();

    // R8 pipe-mode configuration
    push(mkHdr(3, 2, 11, 0, 1));
    push(32'h0000_0010);
    push(32'h1234_5678);
    @(negedge clk);
    chk(cfgStreamOut == 1'b1, "R8 stream out set", 64'(cfgStreamOut), 64'd1);
    chk(cfgSoftReset == 32'h1234_5678, "R8 soft reset", 64'(cfgSoftReset), 64'h1234_5678);
    accept();
    push(mkHdr(3, 2, 11, 0, 2));     // wrong length: rejected
    push(32'h0000_0000);
    push(32'h0000_0000);
    push(32'hFFFF_FFFF);
    @(negedge clk);
    chk(cfgStreamOut == 1'b1 && cfgSoftReset == 32'h1234_5678, "R8 rejected keeps cfg",
        64'(cfgSoftReset), 64'h1234_5678);
    chk(errSticky == 1'b1, "R4 pipe-mode length error", 64'(errSticky), 64'd1);
    startProbe("R4 after bad pipe-mode");
    push(mkHdr(3, 2, 11, 0, 1));
    push(32'hFFFF_FFEF);
    push(32'h0000_0000);
    @(negedge clk);
    chk(cfgStreamOut == 1'b0 && cfgSoftReset == 32'd0, "R8 cfg cleared", 64'({cfgStreamOut, cfgSoftReset}), 64'd0);
    accept();
    chk(errSticky == 1'b1, "R7 sticky after legal", 64'(errSticky), 64'd1);

    // R1 R2: every wrong combination of identity fields
    for (int ct = 0; ct < 8; ct++)
      for (int pp = 0; pp < 4; pp++)
        for (int op = 0; op < 16; op++) begin
          if (!(ct == 3 && pp == 2 && op == 11)) begin
            int ln;
            ln = (ct + pp + op) % 4;
            doReset();
            sendPat(mkHdr(ct, pp, op, 33, ln), ln + 1, 5);
            @(negedge clk);
            chk(outValid == 1'b0, "R1 no strobe", 64'(outValid), 64'd0);
            chk(errSticky == 1'b1, "R1 error flag", 64'(errSticky), 64'd1);
            startProbe("R2 skip");
          end
        end

    // R3: unknown sub-numbers
    for (int s = 0; s < 128; s++) begin
      if (tbTotal(s) == 0) begin
        doReset();
        sendPat(mkHdr(3, 2, 11, s, 1), 2, s);
        @(negedge clk);
        chk(outValid == 1'b0 && errSticky == 1'b1, "R3 unknown sub", 64'({outValid, errSticky}), 64'b01);
        startProbe("R3 skip");
      end
    end

    // R4: length off by one in both directions
    for (int s = 0; s < 128; s++) begin
      int t;
      t = tbTotal(s);
      if (t != 0) begin
        for (int d = -1; d <= 1; d += 2) begin
          int ln;
          ln = t - 2 + d;
          if (ln >= 0) begin
            doReset();
            sendPat(mkHdr(3, 2, 11, s, ln), ln + 1, s);
            @(negedge clk);
            chk(outValid == 1'b0 && errSticky == 1'b1, "R4 length mismatch", 64'({outValid, errSticky}), 64'b01);
            startProbe("R4 skip");
            chk(errSticky == 1'b1, "R7 still set", 64'(errSticky), 64'd1);
          end
        end
      end
    end

    // R2 R10: maximum length field skip
    doReset();
    sendPat(mkHdr(0, 0, 0, 0, 4095), 4096, 1);
    startProbe("R2 max skip");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule